// File: doc/BRIEF.md
# NVM Checksum Validate-and-Update Engine

This block checks or repairs the 16-bit additive checksum of a nonvolatile memory image. It sees the memory only through an abstract word read port and an abstract word write port. Each port uses a request/acknowledge handshake. The physical memory interface is outside the block.

A one-cycle start pulse launches an operation, and the mode bit sampled with it selects what the operation does. In validate mode the engine reads every word from offset 0 up to and including the checksum word. It adds them with wrap-around and tests whether the total equals the fixed signature 0xBABA. In update mode the engine reads only the words that come before the checksum word. It then writes the value that brings the total to the signature into the checksum slot.

Completion is a single-cycle `done_o` pulse, with `pass_o` or `err_o` beside it. `done_o` with neither flag means the checksum did not match.

Top module: `nvm_csum_engine`

## Requirements
- R1: In validate mode (`mode_i`=0), a start reads offsets 0, 1, ... up to the checksum offset `CSUM_OFS` in increasing order. Only one read is outstanding at a time. `rd_req_o` and `rd_addr_o` stay unchanged until the cycle in which `rd_ack_i` is high, and no write is issued.
- R2: Words are added as an unsigned 16-bit sum that wraps modulo 65536.
- R3: At the end of validate mode, `done_o` pulses with `pass_o`=1 when the sum over offsets 0..`CSUM_OFS` equals 0xBABA. Otherwise `done_o` pulses with `pass_o`=0 and `err_o`=0.
- R4: In update mode (`mode_i`=1), the engine reads only offsets 0..`CSUM_OFS`-1, in increasing order, and never reads the checksum offset.
- R5: Update mode then issues one write to offset `CSUM_OFS` carrying (0xBABA - sum) mod 65536. When that write is acknowledged without error, `done_o` pulses with `pass_o`=1.
- R6: A read acknowledged with `rd_err_i`=1 ends the operation. The next cycle has `done_o`=1 and `err_o`=1, and no further read or write follows.
- R7: A write acknowledged with `wr_err_i`=1 ends the operation with `done_o`=1, `err_o`=1 and `pass_o`=0.
- R8: A start pulse that arrives while an operation is in progress is ignored. That operation keeps its mode and address sequence, and it produces exactly one `done_o`.
- R9: While in reset and directly after it, `rd_req_o`, `wr_req_o` and `done_o` are 0.
- R10: `done_o` is high for a single cycle per operation. `pass_o` and `err_o` are only high together with `done_o`, and never both at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| mode_i | input | 1 | 0 = validate, 1 = update; sampled with start |
| done_o | output | 1 | Operation finished (one cycle) |
| pass_o | output | 1 | Checksum good / write completed |
| err_o | output | 1 | Read or write access error |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Word offset being read |
| rd_ack_i | input | 1 | Read acknowledge, qualifies data and error |
| rd_err_i | input | 1 | Read failed |
| rd_data_i | input | 16 | Read word |
| wr_req_o | output | 1 | Write request, held until acknowledged |
| wr_addr_o | output | ADDR_W | Write offset (always the checksum offset) |
| wr_data_o | output | 16 | Checksum value to store |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_err_i | input | 1 | Write failed |

## Verification
Assertions check the following on every cycle:
- A request is held with a stable address until it is acknowledged.
- Reads and writes are never requested together, and read addresses stay inside the mode's range.
- A read or write error produces an error completion on the next cycle.
- The result flags stay consistent with `done_o`.

The bench scenarios show the rest:
- The arithmetic: wrap-around sums, the pass/fail decision against 0xBABA, and the exact checksum value written in update mode.
- Read order and the count of reads up to the point of an injected error.
- That an image repaired by update mode then passes validation, and that a start arriving mid-operation has no effect.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;

  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] CSUM_SIG = 16'hBABA;

  typedef enum logic {
    M_VALIDATE = 1'b0,
    M_UPDATE   = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2
  } state_e;

endpackage

// File: rtl/nvm_csum_acc.sv
module nvm_csum_acc
  import nvm_csum_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter logic [DW-1:0] SIG = CSUM_SIG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  output logic          match_o,
  output logic [DW-1:0] fix_o
);

  logic [DW-1:0] acc_q;
  logic [DW-1:0] sum_nxt;

  // modulo 2^DW by width truncation
  assign sum_nxt = acc_q + data_i;
  assign match_o = (sum_nxt == SIG);
  assign fix_o   = SIG - acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= sum_nxt;
  end

  p_no_clr_add_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && en_i));

endmodule

// File: rtl/nvm_csum_seq.sv
module nvm_csum_seq
  import nvm_csum_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned CSUM_OFS = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              rd_ack_i,
  input  logic              rd_err_i,
  input  logic              wr_ack_i,
  input  logic              wr_err_i,
  input  logic              sum_match_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              acc_clr_o,
  output logic              acc_en_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              err_o
);

  localparam bit          NO_PRE   = (CSUM_OFS == 0);
  localparam int unsigned UPD_LAST = NO_PRE ? 0 : CSUM_OFS - 1;
  localparam logic [ADDR_W-1:0] VAL_END = ADDR_W'(CSUM_OFS);
  localparam logic [ADDR_W-1:0] UPD_END = ADDR_W'(UPD_LAST);

  state_e            state_q;
  mode_e             mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_addr;
  logic              start_ok;

  assign last_addr = (mode_q == M_UPDATE) ? UPD_END : VAL_END;
  assign start_ok  = (state_q == S_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= M_VALIDATE;
      addr_q  <= '0;
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            mode_q <= mode_e'(mode_i);
            addr_q <= '0;
            if (mode_i && NO_PRE) state_q <= S_WR;
            else                  state_q <= S_RD;
          end
        end
        S_RD: begin
          if (rd_ack_i) begin
            if (rd_err_i) begin
              done_o  <= 1'b1;
              err_o   <= 1'b1;
              state_q <= S_IDLE;
            end else if (addr_q == last_addr) begin
              if (mode_q == M_VALIDATE) begin
                done_o  <= 1'b1;
                pass_o  <= sum_match_i;
                state_q <= S_IDLE;
              end else begin
                state_q <= S_WR;
              end
            end else begin
              addr_q <= addr_q + 1'b1;
            end
          end
        end
        S_WR: begin
          if (wr_ack_i) begin
            done_o  <= 1'b1;
            pass_o  <= !wr_err_i;
            err_o   <= wr_err_i;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q == S_RD);
  assign rd_addr_o = addr_q;
  assign wr_req_o  = (state_q == S_WR);
  assign wr_addr_o = VAL_END;
  assign acc_clr_o = start_ok;
  assign acc_en_o  = rd_req_o && rd_ack_i && !rd_err_i;

  p_req_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  p_wr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> wr_req_o);

  p_rd_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o <= VAL_END));

  p_rd_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && mode_q == M_UPDATE) |-> (rd_addr_o < VAL_END));

  p_rd_err_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_ack_i && rd_err_i) |=> (done_o && err_o && !rd_req_o && !wr_req_o));

  p_wr_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_ack_i && wr_err_i) |=> (done_o && err_o && !pass_o));

  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i && start_i) |=> (rd_req_o && $stable(mode_q)));

  p_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pass_o || err_o) |-> done_o) and !(pass_o && err_o));

endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine
  import nvm_csum_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned CSUM_OFS = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              err_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic              rd_err_i,
  input  logic [15:0]       rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o,
  input  logic              wr_ack_i,
  input  logic              wr_err_i
);

  logic acc_clr;
  logic acc_en;
  logic sum_match;

  nvm_csum_seq #(
    .ADDR_W   (ADDR_W),
    .CSUM_OFS (CSUM_OFS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .rd_ack_i    (rd_ack_i),
    .rd_err_i    (rd_err_i),
    .wr_ack_i    (wr_ack_i),
    .wr_err_i    (wr_err_i),
    .sum_match_i (sum_match),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .wr_req_o    (wr_req_o),
    .wr_addr_o   (wr_addr_o),
    .acc_clr_o   (acc_clr),
    .acc_en_o    (acc_en),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .err_o       (err_o)
  );

  nvm_csum_acc #(
    .DW  (WORD_W),
    .SIG (CSUM_SIG)
  ) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (acc_clr),
    .en_i    (acc_en),
    .data_i  (rd_data_i),
    .match_o (sum_match),
    .fix_o   (wr_data_o)
  );

  p_one_port_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));

  p_wr_data_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && $past(wr_req_o)) |-> $stable(wr_data_o));

endmodule

// File: tb/tb_nvm_csum_engine.sv
module tb_nvm_csum_engine;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int CSUM_OFS   = 63;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0;
  logic done_o, pass_o, err_o;
  logic rd_req_o, wr_req_o;
  logic [ADDR_W-1:0] rd_addr_o, wr_addr_o;
  logic rd_ack_i = 1'b0, rd_err_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic [15:0] wr_data_o;
  logic wr_ack_i = 1'b0, wr_err_i = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_csum_engine #(.ADDR_W(ADDR_W), .CSUM_OFS(CSUM_OFS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .done_o(done_o), .pass_o(pass_o), .err_o(err_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_err_i(rd_err_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_ack_i(wr_ack_i), .wr_err_i(wr_err_i)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] mem [0:CSUM_OFS];
  logic [1:0] exp_q [$];   // {pass, err}
  int exp_addr = 0;
  int cur_mode = 0;
  bit inj_rd_err = 0;
  int rd_err_at = 0;
  bit inj_wr_err = 0;
  bit exp_wr = 0;
  logic [15:0] exp_wr_data = '0;
  int wr_count = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_to(int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  // read responder: checks order/bounds, variable latency
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      rd_ack_i = 1'b0;
      rd_err_i = 1'b0;
      if (rd_req_o) begin
        if (wait_cnt == 0) begin
          chk(int'(rd_addr_o) == exp_addr, cur_mode ? "R4 order" : "R1 order",
              32'(rd_addr_o), 32'(exp_addr));
          if (cur_mode == 1)
            chk(int'(rd_addr_o) < CSUM_OFS, "R4 bound", 32'(rd_addr_o), 32'(CSUM_OFS - 1));
          rd_ack_i  = 1'b1;
          rd_data_i = mem[rd_addr_o];
          rd_err_i  = inj_rd_err && (int'(rd_addr_o) == rd_err_at);
          exp_addr++;
          wait_cnt = int'(rd_addr_o) % 3;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  // write responder
  initial begin
    bit seen = 0;
    forever begin
      @(negedge clk);
      wr_ack_i = 1'b0;
      wr_err_i = 1'b0;
      if (wr_req_o) begin
        if (!seen) begin
          seen = 1;
        end else begin
          seen = 0;
          wr_count++;
          chk(exp_wr, "R5 unexpected write", 32'(wr_addr_o), 32'hFFFF_FFFF);
          chk(int'(wr_addr_o) == CSUM_OFS, "R5 addr", 32'(wr_addr_o), 32'(CSUM_OFS));
          chk(wr_data_o == exp_wr_data, "R5 data", 32'(wr_data_o), 32'(exp_wr_data));
          wr_ack_i = 1'b1;
          wr_err_i = inj_wr_err;
          if (!inj_wr_err) mem[wr_addr_o] = wr_data_o;
        end
      end
    end
  end

  // result monitor / scoreboard
  initial begin
    logic prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        chk(!(prev_done && done_o), "R10 pulse", 32'(done_o), 32'd0);
        chk(!(pass_o && err_o) && ((pass_o || err_o) ? done_o : 1'b1), "R10 flags",
            {29'd0, done_o, pass_o, err_o}, 32'd4);
        if (done_o) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8 extra done", 32'd1, 32'd0);
          end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            chk({pass_o, err_o} == e, "R3/R5/R6/R7 result", 32'({pass_o, err_o}), 32'(e));
          end
        end
        prev_done = done_o;
      end
    end
  end

  task automatic run_op(int mode, logic [1:0] exp_res, bit extra_start);
    cur_mode = mode;
    exp_addr = 0;
    exp_q.push_back(exp_res);
    @(negedge clk);
    start_i = 1'b1;
    mode_i  = mode[0];
    @(negedge clk);
    start_i = 1'b0;
    if (extra_start) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      mode_i  = ~mode[0];
      @(negedge clk);
      start_i = 1'b0;
    end
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i <= CSUM_OFS; i++) mem[i] = 16'(i * 16'h1357 + 16'h0042);
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!rd_req_o && !wr_req_o && !done_o, "R9 in reset",
        {29'd0, rd_req_o, wr_req_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!rd_req_o && !wr_req_o && !done_o, "R9 after reset",
        {29'd0, rd_req_o, wr_req_o, done_o}, 32'd0);

    // R1/R3: valid image passes
    mem[CSUM_OFS] = 16'hBABA - sum_to(CSUM_OFS - 1);
    run_op(0, 2'b10, 0);
    chk(exp_addr == CSUM_OFS + 1, "R1 read count", 32'(exp_addr), 32'(CSUM_OFS + 1));

    // R3: corrupted image fails
    mem[5] = mem[5] ^ 16'h0100;
    run_op(0, 2'b00, 0);

    // R2: wrapping sum of large words still passes
    for (int i = 0; i < CSUM_OFS; i++) mem[i] = 16'hFFF0 - 16'(i);
    mem[CSUM_OFS] = 16'hBABA - sum_to(CSUM_OFS - 1);
    run_op(0, 2'b10, 0);

    // R4/R5: update then re-validate
    for (int i = 0; i <= CSUM_OFS; i++) mem[i] = 16'(i * 16'h0F0F + 16'h1234);
    exp_wr = 1;
    exp_wr_data = 16'hBABA - sum_to(CSUM_OFS - 1);
    wr_count = 0;
    run_op(1, 2'b10, 0);
    chk(exp_addr == CSUM_OFS, "R4 read count", 32'(exp_addr), 32'(CSUM_OFS));
    chk(wr_count == 1, "R5 write count", 32'(wr_count), 32'd1);
    chk(mem[CSUM_OFS] == exp_wr_data, "R5 stored", 32'(mem[CSUM_OFS]), 32'(exp_wr_data));
    exp_wr = 0;
    run_op(0, 2'b10, 0);

    // R7: write error
    mem[CSUM_OFS] = 16'h0000;
    exp_wr = 1;
    inj_wr_err = 1;
    exp_wr_data = 16'hBABA - sum_to(CSUM_OFS - 1);
    run_op(1, 2'b01, 0);
    chk(mem[CSUM_OFS] == 16'h0000, "R7 no store", 32'(mem[CSUM_OFS]), 32'd0);
    inj_wr_err = 0;
    exp_wr = 0;

    // R6: read error stops, no write
    inj_rd_err = 1;
    rd_err_at = 10;
    wr_count = 0;
    run_op(1, 2'b01, 0);
    chk(exp_addr == 11, "R6 reads stop", 32'(exp_addr), 32'd11);
    chk(wr_count == 0, "R6 no write", 32'(wr_count), 32'd0);
    run_op(0, 2'b01, 0);
    chk(exp_addr == 11, "R6 validate stop", 32'(exp_addr), 32'd11);
    inj_rd_err = 0;

    // R8: start during validate ignored (reads reach checksum word, no write)
    mem[CSUM_OFS] = 16'hBABA - sum_to(CSUM_OFS - 1);
    run_op(0, 2'b10, 1);
    chk(exp_addr == CSUM_OFS + 1, "R8 mode kept", 32'(exp_addr), 32'(CSUM_OFS + 1));
    repeat (10) @(negedge clk);
    chk(!rd_req_o && !wr_req_o, "R8 idle after", {30'd0, rd_req_o, wr_req_o}, 32'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule